// File: doc/BRIEF.md
# Event Counter Monitor Bank

A bank of eight 64-bit event counters that a host configures and reads through a simple single-cycle register port. Each counter owns an 8-bit event selector that picks one of 256 event strobes, where code 0 is a built-in clock-cycle event that is high on every clock. It also owns a small control register that stores a value for software and has no other effect. A counter advances on each clock in which its selected strobe is high, provided its own enable bit and the global enable are both set.

The per-counter count enables and interrupt enables are each changed through a pair of registers: one that sets bits written as one and one that clears them. A counter that wraps from all ones to zero latches a bit in the overflow status register. Software clears that bit by writing a one to it. A level interrupt stays high while any latched overflow has its interrupt enabled. A global control register holds the enable bit. It also has a self-clearing reset request that returns every counter and mask to zero.

The register port is combinational on read: `rdata_o` reflects `addr_i` in the same cycle. Writes take effect at the next rising clock edge when `we_i` is high. Offsets are in bytes and every register sits on an 8-byte stride. Unmapped or unaligned offsets read as zero and ignore writes.

Top module: `evmon_top`

## Requirements
- R1: After the synchronous reset input, every counter value, control, event select, both masks, overflow status and the global control read as zero, and `irq_o` is low.
- R2: Counter n, whose value register is at 0x000+8n, adds exactly one on each clock in which its selected strobe is high and both its enable bit and the global enable are set. Otherwise it holds its value.
- R3: Event code 0x00 counts every clock regardless of the strobe inputs. Code k (1..255) follows `evt_i[k]`.
- R4: A write to a value register loads the written 64-bit value and takes priority over an increment in the same cycle. A read returns the live count.
- R5: Writing ones to 0x410 sets the matching count-enable bits and writing ones to 0x418 clears them. Bit n is counter n, and bits written as zero are unchanged. Both offsets read back the current mask in bits [7:0].
- R6: Offsets 0x420 (set) and 0x428 (clear) manage the interrupt-enable mask with the same bit layout, write-one behaviour and read-back as R5.
- R7: An increment of counter n from all ones gives zero and sets bit n of the overflow status at 0x440.
- R8: Writing ones to 0x440 clears the matching status bits. When a wrap and a clear hit the same bit in one cycle, the bit ends up set. Status bits are otherwise sticky.
- R9: `irq_o` is high exactly while some status bit n and interrupt-enable bit n are both set.
- R10: Bit 0 of the global control at 0x400 is the global enable and reads back. Writing zero to it stops all counting.
- R11: Writing bit 1 of 0x400 requests a reset. On the following clock edge all counters, controls, event selects, both masks and the status are zeroed. Bit 1 always reads as zero.
- R12: The event-select register at 0x200+8n keeps bits [7:0] and reads zero above them. The control register at 0x100+8n keeps bits [7:0] and reads them back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| addr_i | input | 11 | Byte offset of the register accessed |
| we_i | input | 1 | Write strobe, applied at the next rising edge |
| wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Read data for `addr_i`, combinational |
| evt_i | input | 255 | Event strobes, index k matches event code k (1..255) |
| irq_o | output | 1 | Level interrupt for enabled overflows |

## Verification
The bench drives a counter to all ones and lets it wrap while software clears the same status bit in that cycle. A design that let the clear win would drop an overflow and the interrupt would fall. It writes a value register while that counter is counting, which catches a design that adds one on top of the loaded value. It also writes set and clear masks with sparse patterns, which exposes a register that overwrites bits written as zero instead of leaving them alone. Finally, it issues the self-clearing reset and checks that every field is zero afterwards and that bit 1 reads zero; a design that latched the request would hold the unit in reset.

// File: rtl/evmon_pkg.sv
package evmon_pkg;
    localparam int NUM_CNT = 8;
    localparam int SEL_W   = 8;
    localparam int NUM_EVT = 1 << SEL_W;
    localparam int REG_W   = 64;
    localparam int CNT_W   = 64;
    localparam int CTL_W   = 8;
    localparam int ADDR_W  = 11;
    localparam int IDX_W   = $clog2(NUM_CNT);

    localparam logic [2:0] BANK_VAL = 3'd0;
    localparam logic [2:0] BANK_CTL = 3'd1;
    localparam logic [2:0] BANK_EVT = 3'd2;
    localparam logic [2:0] BANK_GLB = 3'd4;

    localparam logic [4:0] SLOT_CR  = 5'h00;
    localparam logic [4:0] SLOT_ENS = 5'h02;
    localparam logic [4:0] SLOT_ENC = 5'h03;
    localparam logic [4:0] SLOT_IES = 5'h04;
    localparam logic [4:0] SLOT_IEC = 5'h05;
    localparam logic [4:0] SLOT_OVF = 5'h08;

    typedef enum logic [2:0] {
        RD_NONE, RD_VAL, RD_CTL, RD_EVT, RD_CR, RD_EN, RD_IE, RD_OVF
    } rd_e;

    typedef struct packed {
        rd_e              rd;
        logic [IDX_W-1:0] idx;
        logic             val_we;
        logic             ctl_we;
        logic             evt_we;
        logic             cr_we;
        logic             ens_we;
        logic             enc_we;
        logic             ies_we;
        logic             iec_we;
        logic             ovf_we;
    } dec_t;
endpackage

// File: rtl/evmon_regdec.sv
module evmon_regdec
    import evmon_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    output dec_t              dec_o
);
    logic [2:0] bank;
    logic [4:0] slot;
    logic       aligned;
    logic       cnt_ok;

    assign bank    = addr_i[ADDR_W-1:8];
    assign slot    = addr_i[7:3];
    assign aligned = (addr_i[2:0] == 3'b000);
    assign cnt_ok  = aligned && (slot < 5'(NUM_CNT));

    always_comb begin
        dec_o.rd     = RD_NONE;
        dec_o.idx    = addr_i[IDX_W+2:3];
        dec_o.val_we = 1'b0;
        dec_o.ctl_we = 1'b0;
        dec_o.evt_we = 1'b0;
        dec_o.cr_we  = 1'b0;
        dec_o.ens_we = 1'b0;
        dec_o.enc_we = 1'b0;
        dec_o.ies_we = 1'b0;
        dec_o.iec_we = 1'b0;
        dec_o.ovf_we = 1'b0;
        case (bank)
            BANK_VAL: if (cnt_ok) begin
                dec_o.rd     = RD_VAL;
                dec_o.val_we = we_i;
            end
            BANK_CTL: if (cnt_ok) begin
                dec_o.rd     = RD_CTL;
                dec_o.ctl_we = we_i;
            end
            BANK_EVT: if (cnt_ok) begin
                dec_o.rd     = RD_EVT;
                dec_o.evt_we = we_i;
            end
            BANK_GLB: if (aligned) begin
                case (slot)
                    SLOT_CR:  begin dec_o.rd = RD_CR;  dec_o.cr_we  = we_i; end
                    SLOT_ENS: begin dec_o.rd = RD_EN;  dec_o.ens_we = we_i; end
                    SLOT_ENC: begin dec_o.rd = RD_EN;  dec_o.enc_we = we_i; end
                    SLOT_IES: begin dec_o.rd = RD_IE;  dec_o.ies_we = we_i; end
                    SLOT_IEC: begin dec_o.rd = RD_IE;  dec_o.iec_we = we_i; end
                    SLOT_OVF: begin dec_o.rd = RD_OVF; dec_o.ovf_we = we_i; end
                    default: ;
                endcase
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/evmon_counter.sv
module evmon_counter
    import evmon_pkg::*;
(
    input  logic               clk_i,
    input  logic               clr_i,
    input  logic               val_we_i,
    input  logic               ctl_we_i,
    input  logic               evt_we_i,
    input  logic [REG_W-1:0]   wdata_i,
    input  logic [NUM_EVT-1:0] evt_vec_i,
    input  logic               run_i,
    output logic [CNT_W-1:0]   value_o,
    output logic [CTL_W-1:0]   ctl_o,
    output logic [SEL_W-1:0]   sel_o,
    output logic               wrap_o
);
    logic step;

    assign step   = run_i & evt_vec_i[sel_o];
    assign wrap_o = step & ~val_we_i & (&value_o);

    always_ff @(posedge clk_i) begin
        if (clr_i) begin
            value_o <= '0;
            ctl_o   <= '0;
            sel_o   <= '0;
        end else begin
            if (val_we_i)
                value_o <= wdata_i[CNT_W-1:0];
            else if (step)
                value_o <= value_o + 1'b1;
            if (ctl_we_i)
                ctl_o <= wdata_i[CTL_W-1:0];
            if (evt_we_i)
                sel_o <= wdata_i[SEL_W-1:0];
        end
    end

    // R2: one step per qualifying clock
    p_count_step_r2: assert property (@(posedge clk_i) disable iff (clr_i)
        (step && !val_we_i) |=> (value_o == $past(value_o) + 1'b1));

    // R2: no qualifying event means no change
    p_hold_r2: assert property (@(posedge clk_i) disable iff (clr_i)
        (!step && !val_we_i) |=> $stable(value_o));

    // R4: direct load wins over the increment
    p_load_r4: assert property (@(posedge clk_i) disable iff (clr_i)
        val_we_i |=> (value_o == $past(wdata_i[CNT_W-1:0])));

    // R7: a wrap leaves the counter at zero
    p_wrap_zero_r7: assert property (@(posedge clk_i) disable iff (clr_i)
        wrap_o |=> (value_o == '0));
endmodule

// File: rtl/evmon_mask.sv
module evmon_mask
    import evmon_pkg::*;
(
    input  logic               clk_i,
    input  logic               clr_i,
    input  logic               set_we_i,
    input  logic               clr_we_i,
    input  logic [NUM_CNT-1:0] bits_i,
    output logic [NUM_CNT-1:0] mask_o
);
    always_ff @(posedge clk_i) begin
        if (clr_i)
            mask_o <= '0;
        else if (set_we_i)
            mask_o <= mask_o | bits_i;
        else if (clr_we_i)
            mask_o <= mask_o & ~bits_i;
    end

    // R5 (and R6 for the interrupt-enable instance): ones written set bits
    p_w1s_r5: assert property (@(posedge clk_i) disable iff (clr_i)
        set_we_i |=> ((mask_o & $past(bits_i)) == $past(bits_i)));

    // R5 (and R6): ones written clear bits, zeros leave the rest alone
    p_w1c_r5: assert property (@(posedge clk_i) disable iff (clr_i)
        clr_we_i |=> (mask_o == ($past(mask_o) & ~$past(bits_i))));
endmodule

// File: rtl/evmon_ovf.sv
module evmon_ovf
    import evmon_pkg::*;
(
    input  logic               clk_i,
    input  logic               clr_i,
    input  logic [NUM_CNT-1:0] wrap_i,
    input  logic               w1c_we_i,
    input  logic [NUM_CNT-1:0] bits_i,
    input  logic [NUM_CNT-1:0] ie_i,
    output logic [NUM_CNT-1:0] status_o,
    output logic               irq_o
);
    logic [NUM_CNT-1:0] wipe;

    assign wipe  = w1c_we_i ? bits_i : '0;
    assign irq_o = |(status_o & ie_i);

    always_ff @(posedge clk_i) begin
        if (clr_i)
            status_o <= '0;
        else
            status_o <= (status_o & ~wipe) | wrap_i;
    end

    // R7: each wrap latches its bit
    p_wrap_sets_r7: assert property (@(posedge clk_i) disable iff (clr_i)
        (|wrap_i) |=> ((status_o & $past(wrap_i)) == $past(wrap_i)));

    // R8: cleared bits without a concurrent wrap go to zero
    p_w1c_r8: assert property (@(posedge clk_i) disable iff (clr_i)
        w1c_we_i |=> ((status_o & $past(bits_i & ~wrap_i)) == '0));

    // R8: without a clear write nothing is lost
    p_sticky_r8: assert property (@(posedge clk_i) disable iff (clr_i)
        !w1c_we_i |=> ((status_o & $past(status_o)) == $past(status_o)));
endmodule

// File: rtl/evmon_top.sv
module evmon_top
    import evmon_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               we_i,
    input  logic [REG_W-1:0]   wdata_i,
    output logic [REG_W-1:0]   rdata_o,
    input  logic [NUM_EVT-1:1] evt_i,
    output logic               irq_o
);
    dec_t               dec;
    logic               glb_en_q;
    logic               srst_q;
    logic               clr;
    logic [NUM_EVT-1:0] evt_vec;
    logic [NUM_CNT-1:0] en_mask;
    logic [NUM_CNT-1:0] ie_mask;
    logic [NUM_CNT-1:0] ovf_status;
    logic [NUM_CNT-1:0] wrap;
    logic [NUM_CNT-1:0] run;
    logic [CNT_W-1:0]   cnt_val [NUM_CNT];
    logic [CTL_W-1:0]   cnt_ctl [NUM_CNT];
    logic [SEL_W-1:0]   cnt_sel [NUM_CNT];

    assign clr     = rst_i | srst_q;
    assign evt_vec = {evt_i, 1'b1};
    assign run     = {NUM_CNT{glb_en_q}} & en_mask;

    evmon_regdec u_dec (
        .addr_i (addr_i),
        .we_i   (we_i),
        .dec_o  (dec)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            glb_en_q <= 1'b0;
            srst_q   <= 1'b0;
        end else if (dec.cr_we) begin
            glb_en_q <= wdata_i[0];
            srst_q   <= wdata_i[1];
        end else begin
            srst_q   <= 1'b0;
        end
    end

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        logic hit_idx;
        assign hit_idx = (dec.idx == IDX_W'(g));
        evmon_counter u_cnt (
            .clk_i     (clk_i),
            .clr_i     (clr),
            .val_we_i  (dec.val_we & hit_idx),
            .ctl_we_i  (dec.ctl_we & hit_idx),
            .evt_we_i  (dec.evt_we & hit_idx),
            .wdata_i   (wdata_i),
            .evt_vec_i (evt_vec),
            .run_i     (run[g]),
            .value_o   (cnt_val[g]),
            .ctl_o     (cnt_ctl[g]),
            .sel_o     (cnt_sel[g]),
            .wrap_o    (wrap[g])
        );
    end

    evmon_mask u_en (
        .clk_i    (clk_i),
        .clr_i    (clr),
        .set_we_i (dec.ens_we),
        .clr_we_i (dec.enc_we),
        .bits_i   (wdata_i[NUM_CNT-1:0]),
        .mask_o   (en_mask)
    );

    evmon_mask u_ie (
        .clk_i    (clk_i),
        .clr_i    (clr),
        .set_we_i (dec.ies_we),
        .clr_we_i (dec.iec_we),
        .bits_i   (wdata_i[NUM_CNT-1:0]),
        .mask_o   (ie_mask)
    );

    evmon_ovf u_ovf (
        .clk_i    (clk_i),
        .clr_i    (clr),
        .wrap_i   (wrap),
        .w1c_we_i (dec.ovf_we),
        .bits_i   (wdata_i[NUM_CNT-1:0]),
        .ie_i     (ie_mask),
        .status_o (ovf_status),
        .irq_o    (irq_o)
    );

    always_comb begin
        rdata_o = '0;
        case (dec.rd)
            RD_VAL: rdata_o[CNT_W-1:0]   = cnt_val[dec.idx];
            RD_CTL: rdata_o[CTL_W-1:0]   = cnt_ctl[dec.idx];
            RD_EVT: rdata_o[SEL_W-1:0]   = cnt_sel[dec.idx];
            RD_CR:  rdata_o[0]           = glb_en_q;
            RD_EN:  rdata_o[NUM_CNT-1:0] = en_mask;
            RD_IE:  rdata_o[NUM_CNT-1:0] = ie_mask;
            RD_OVF: rdata_o[NUM_CNT-1:0] = ovf_status;
            default: rdata_o = '0;
        endcase
    end

    // R11: the reset request empties masks and status on the next edge
    p_selfclr_r11: assert property (@(posedge clk_i) disable iff (rst_i)
        srst_q |=> (en_mask == '0 && ie_mask == '0 && ovf_status == '0));

    // R9: an interrupt needs a latched overflow
    p_irq_src_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        irq_o |-> (ovf_status != '0));

    // R10: with the global enable off no counter wraps
    p_stop_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        !glb_en_q |-> (wrap == '0));
endmodule

// File: tb/evmon_top_tb_top.sv
`timescale 1ns/1ps
module evmon_top_tb_top;
    logic         clk = 1'b0;
    logic         rst;
    logic [10:0]  addr;
    logic         we;
    logic [63:0]  wdata;
    logic [63:0]  rdata;
    logic [255:1] evt;
    logic         irq;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    evmon_top dut_i (
        .clk_i   (clk),
        .rst_i   (rst),
        .addr_i  (addr),
        .we_i    (we),
        .wdata_i (wdata),
        .rdata_o (rdata),
        .evt_i   (evt),
        .irq_o   (irq)
    );

    // behavioural reference model
    logic [63:0] m_cnt [8];
    logic [7:0]  m_ctl [8];
    logic [7:0]  m_sel [8];
    logic [7:0]  m_en, m_ie, m_ovf;
    logic        m_ge, m_sr;

    always @(posedge clk) begin : model
        logic [7:0]   wraps;
        logic [255:0] ev;
        logic         inc;
        ev = {evt, 1'b1};
        if (rst) begin
            for (int n = 0; n < 8; n++) begin
                m_cnt[n] = 0; m_ctl[n] = 0; m_sel[n] = 0;
            end
            m_en = 0; m_ie = 0; m_ovf = 0; m_ge = 0; m_sr = 0;
        end else begin
            if (m_sr) begin
                for (int n = 0; n < 8; n++) begin
                    m_cnt[n] = 0; m_ctl[n] = 0; m_sel[n] = 0;
                end
                m_en = 0; m_ie = 0; m_ovf = 0;
            end else begin
                wraps = 0;
                for (int n = 0; n < 8; n++) begin
                    inc = m_ge && m_en[n] && ev[m_sel[n]];
                    if (we && addr == 11'(n * 8))
                        m_cnt[n] = wdata;
                    else if (inc) begin
                        if (m_cnt[n] == 64'hFFFF_FFFF_FFFF_FFFF) wraps[n] = 1'b1;
                        m_cnt[n] = m_cnt[n] + 1;
                    end
                    if (we && addr == 11'(12'h100 + n * 8)) m_ctl[n] = wdata[7:0];
                    if (we && addr == 11'(12'h200 + n * 8)) m_sel[n] = wdata[7:0];
                end
                if (we && addr == 11'h410) m_en = m_en | wdata[7:0];
                if (we && addr == 11'h418) m_en = m_en & ~wdata[7:0];
                if (we && addr == 11'h420) m_ie = m_ie | wdata[7:0];
                if (we && addr == 11'h428) m_ie = m_ie & ~wdata[7:0];
                if (we && addr == 11'h440) m_ovf = m_ovf & ~wdata[7:0];
                m_ovf = m_ovf | wraps;
            end
            if (we && addr == 11'h400) begin
                m_ge = wdata[0];
                m_sr = wdata[1];
            end else begin
                m_sr = 1'b0;
            end
        end
    end

    function automatic logic [63:0] m_read(input logic [10:0] a);
        int n;
        n = int'(a[5:3]);
        if (a[2:0] != 0) return 64'h0;
        if (a[10:6] == 5'h00) return m_cnt[n];
        if (a[10:6] == 5'h04) return {56'h0, m_ctl[n]};
        if (a[10:6] == 5'h08) return {56'h0, m_sel[n]};
        case (a)
            11'h400: return {63'h0, m_ge};
            11'h410, 11'h418: return {56'h0, m_en};
            11'h420, 11'h428: return {56'h0, m_ie};
            11'h440: return {56'h0, m_ovf};
            default: return 64'h0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    // R9: the interrupt level is compared on every clock
    always @(negedge clk) begin
        if (!rst) chk("R9 irq level", {63'h0, irq}, {63'h0, |(m_ovf & m_ie)});
    end

    task automatic wr(input logic [10:0] a, input logic [63:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        #1 we = 1'b0;
    endtask

    task automatic rd(input logic [10:0] a, input string tag);
        @(negedge clk);
        addr = a;
        #1 chk(tag, rdata, m_read(a));
    endtask

    task automatic rd_lit(input logic [10:0] a, input string tag, input logic [63:0] exp);
        @(negedge clk);
        addr = a;
        #1 chk(tag, rdata, exp);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic rand_evt();
        for (int k = 0; k < 8; k++) evt[k*32 + 1 +: 31] = 31'($urandom);
        evt[255] = 1'($urandom);
    endtask

    initial begin
        #2_000_000;
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; we = 1'b0; addr = 0; wdata = 0; evt = '0;
        idle(3);
        @(negedge clk) rst = 1'b0;

        // R1: everything zero after reset
        for (int n = 0; n < 8; n++) begin
            rd_lit(11'(n*8), "R1 value", 0);
            rd_lit(11'(12'h100 + n*8), "R1 ctl", 0);
            rd_lit(11'(12'h200 + n*8), "R1 sel", 0);
        end
        rd_lit(11'h400, "R1 cr", 0);
        rd_lit(11'h410, "R1 en", 0);
        rd_lit(11'h420, "R1 ie", 0);
        rd_lit(11'h440, "R1 ovf", 0);
        chk("R1 irq", {63'h0, irq}, 64'h0);

        // R3, R2: cycles, strobe 5 and strobe 200
        wr(11'h208, 5);
        wr(11'h210, 200);
        wr(11'h410, 8'h07);
        wr(11'h400, 1);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk) rand_evt();
        end
        @(negedge clk) evt = '0;
        idle(1);
        rd(11'h000, "R3 cycle count");
        rd(11'h008, "R2 strobe5 count");
        rd(11'h010, "R2 strobe200 count");
        rd(11'h018, "R2 disabled counter holds");
        rd_lit(11'h018, "R2 disabled counter zero", 0);

        // R5: sparse clear leaves other bits
        wr(11'h418, 8'h02);
        rd_lit(11'h410, "R5 en after clear", 8'h05);
        rd_lit(11'h418, "R5 en via clear addr", 8'h05);
        wr(11'h410, 8'h80);
        rd_lit(11'h410, "R5 en after set", 8'h85);

        // R10: global enable off stops counting
        wr(11'h400, 0);
        rd_lit(11'h400, "R10 cr reads 0", 0);
        evt = '1;
        idle(5);
        rd(11'h000, "R10 cycles stopped");
        rd(11'h010, "R10 strobe stopped");
        evt = '0;

        // R4: load wins over increment
        wr(11'h400, 1);
        wr(11'h000, 64'd100);
        rd(11'h000, "R4 live count after load");

        // R7, R9, R6: wraps on counter 2 (ie on) and counter 3 (ie off)
        wr(11'h218, 9);
        wr(11'h410, 8'h08);
        wr(11'h420, 8'h04);
        rd_lit(11'h428, "R6 ie readback", 8'h04);
        wr(11'h010, 64'hFFFF_FFFF_FFFF_FFFE);
        wr(11'h018, 64'hFFFF_FFFF_FFFF_FFFF);
        evt[200] = 1'b1; evt[9] = 1'b1;
        idle(3);
        evt = '0;
        idle(1);
        rd(11'h440, "R7 ovf bits");
        rd_lit(11'h440, "R7 ovf 2 and 3", 8'h0C);
        rd(11'h010, "R7 counter after wrap");
        chk("R9 irq high", {63'h0, irq}, 64'h1);

        // R8: clear bit 3 only, bit 2 stays
        wr(11'h440, 8'h08);
        rd_lit(11'h440, "R8 w1c selective", 8'h04);
        // R8: set wins over clear in the same cycle
        wr(11'h010, 64'hFFFF_FFFF_FFFF_FFFF);
        evt[200] = 1'b1;
        wr(11'h440, 8'h04);
        evt = '0;
        rd_lit(11'h440, "R8 set wins", 8'h04);
        wr(11'h440, 8'hFF);
        rd_lit(11'h440, "R8 clear all", 0);

        // R6: clearing ie masks the interrupt
        wr(11'h010, 64'hFFFF_FFFF_FFFF_FFFF);
        evt[200] = 1'b1;
        idle(1);
        evt = '0;
        wr(11'h428, 8'h04);
        rd_lit(11'h420, "R6 ie cleared", 0);
        chk("R6 irq masked", {63'h0, irq}, 64'h0);

        // R12: select and control widths
        wr(11'h238, 64'hFFFF_FFFF_FFFF_FF33);
        rd_lit(11'h238, "R12 sel width", 8'h33);
        wr(11'h128, 64'h1234_5678_9ABC_DEA5);
        rd_lit(11'h128, "R12 ctl readback", 8'hA5);

        // R11: self-clearing reset
        wr(11'h420, 8'hFF);
        wr(11'h400, 2);
        idle(1);
        rd_lit(11'h400, "R11 bit1 reads 0", 0);
        rd_lit(11'h410, "R11 en zero", 0);
        rd_lit(11'h420, "R11 ie zero", 0);
        rd_lit(11'h440, "R11 ovf zero", 0);
        rd_lit(11'h000, "R11 counter zero", 0);
        rd_lit(11'h210, "R11 sel zero", 0);
        rd_lit(11'h128, "R11 ctl zero", 0);

        // random traffic against the model (R2, R4, R5, R7, R8)
        for (int i = 0; i < 1500; i++) begin
            logic [10:0] a;
            logic [63:0] d;
            int pick;
            @(negedge clk) rand_evt();
            pick = $urandom_range(0, 9);
            d = {$urandom, $urandom};
            case (pick)
                0: a = 11'($urandom_range(0, 7) * 8);
                1: a = 11'(12'h200 + $urandom_range(0, 7) * 8);
                2: a = 11'h410;
                3: a = 11'h418;
                4: a = 11'h420;
                5: a = 11'h428;
                6: a = 11'h440;
                7: begin a = 11'h400; d = {63'h0, ($urandom_range(0, 30) == 0) ? 1'b0 : 1'b1}; end
                default: a = 11'h300;
            endcase
            if (pick == 0) d = 64'hFFFF_FFFF_FFFF_FFF0 | 64'($urandom_range(0, 15));
            if (pick == 1) d = 64'($urandom_range(0, 3) * 100);
            if ($urandom_range(0, 1) == 1) wr(a, d);
            rd(11'($urandom_range(0, 7) * 8), "R4 random value read");
            rd(11'h440, "R8 random ovf read");
            rd(11'h410, "R5 random en read");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule